// File: doc/BRIEF.md
# Packed Quad-Byte Left Shifter

This block is a four-lane SIMD shift unit. A 32-bit operand holds four bytes. Each byte is shifted left by the same 3-bit amount, with zeros filling the vacated low bits. No bit moves from one byte into the next. The four shifted bytes make up the low word of a 64-bit result. The high word is filled with copies of bit 7 of the shifted top byte.

Each lane also checks whether its shift has lost information. The test forms a discard value from the sign bit of the original byte and the bits shifted out of it. If any lane reports a loss on an accepted operation, the unit sets a sticky flag at bit 22 of a 32-bit control/status word. The flag stays set until a clear input is asserted. A new overflow always wins over a clear in the same cycle.

The operation is registered. A result and its valid strobe appear one clock edge after the input strobe.

Top module: `qb_shl_top`

## Requirements
- R1: Each byte lane (bits 31..24, 23..16, 15..8, 7..0) of the operand is shifted left by the shift amount independently. Vacated low bits are zero, and bits shifted out of a lane are lost rather than carried into the next lane.
- R2: The shift amount is 3 bits wide and every value 0 to 7 gives a defined result; no operand or shift combination raises an error.
- R3: result_o[31:0] holds the four shifted lanes in their original positions, and each bit of result_o[63:32] equals result_o[31].
- R4: With a shift amount of 0 the operand passes through unchanged, and no overflow is reported.
- R5: For a shift s of 1 to 7, a lane overflows when any of its original bits 7 down to 7-s is 1. This is the same as a nonzero discard value built from s repeats of bit 7 followed by bits 6 down to 7-s.
- R6: When an accepted operation overflows in any lane, status_o[22] becomes 1 on the same edge as the result. An operation never writes 0 to that bit, so the flag is sticky.
- R7: While flag_clr_i is high at a clock edge, status_o[22] becomes 0. The exception is an accepted operation that overflows in that same cycle, in which case the bit is 1.
- R8: All status_o bits other than bit 22 are always 0.
- R9: valid_o is high in exactly the cycle after a cycle with valid_i high. result_o is updated only on those edges and holds its value otherwise.
- R10: While rst_ni is low, result_o, valid_o and status_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| opnd_i | input | 32 | Packed operand, four byte lanes |
| shamt_i | input | 3 | Shift amount applied to every lane |
| flag_clr_i | input | 1 | Clear the sticky overflow flag |
| result_o | output | 64 | Sign-extended packed result |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| status_o | output | 32 | Control/status word, overflow flag at bit 22 |

## Verification
Some properties are checked by assertions on every cycle. These are the sign extension of the high word, the one-cycle valid timing and the hold of the result between operations. Assertions also cover the sticky flag and its priority over clear, the zero-shift pass-through of each lane and the zero value of the unused status bits. Only the bench scenarios can show that each lane's shifted value and overflow decision match the discard rule for every shift amount. The same is true of the absence of carries between lanes, for mixed positive and negative bytes and for the all-zero and all-ones operands.

// File: rtl/qb_shl_pkg.sv
package qb_shl_pkg;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = 4;
  localparam int unsigned SH_W    = $clog2(LANE_W);
  localparam int unsigned WORD_W  = LANE_W * LANES;
  localparam int unsigned RES_W   = 2 * WORD_W;
  localparam int unsigned CSR_W   = 32;
  localparam int unsigned FLAG_POS = 22;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [SH_W-1:0]   shamt_t;
endpackage

// File: rtl/qb_shl_lane.sv
module qb_shl_lane
  import qb_shl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  lane_t  lane_i,
  input  shamt_t shamt_i,
  output lane_t  lane_o,
  output logic   ovf_o
);
  lane_t lost_bits;

  always_comb begin
    lane_o = lane_i << shamt_i;
    // bits 7 down to 7-s of the original lane
    lost_bits = lane_i >> (shamt_t'(LANE_W - 1) - shamt_i);
    ovf_o = (shamt_i != '0) && (lost_bits != '0);
  end

  AST_ZERO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shamt_i == '0) |-> (!ovf_o && lane_o == lane_i)); // R4
  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shamt_i != '0) |-> (lane_o[0] == 1'b0)); // R1
endmodule

// File: rtl/qb_shl_flag.sv
module qb_shl_flag
  import qb_shl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  output logic [CSR_W-1:0] csr_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  always_comb begin
    csr_o = '0;
    csr_o[FLAG_POS] = flag_q;
  end

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_o[FLAG_POS] && !clr_i) |=> csr_o[FLAG_POS]); // R6
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> csr_o[FLAG_POS]); // R7
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !csr_o[FLAG_POS]); // R7
endmodule

// File: rtl/qb_shl_top.sv
module qb_shl_top
  import qb_shl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] opnd_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              flag_clr_i,
  output logic [RES_W-1:0]  result_o,
  output logic              valid_o,
  output logic [CSR_W-1:0]  status_o
);
  logic [WORD_W-1:0] packed_d;
  logic [LANES-1:0]  lane_ovf;
  logic [RES_W-1:0]  result_q;
  logic              valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qb_shl_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lane_i  (opnd_i[g*LANE_W +: LANE_W]),
      .shamt_i (shamt_i),
      .lane_o  (packed_d[g*LANE_W +: LANE_W]),
      .ovf_o   (lane_ovf[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= {{WORD_W{packed_d[WORD_W-1]}}, packed_d};
    end
  end

  qb_shl_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (valid_i && (|lane_ovf)),
    .clr_i  (flag_clr_i),
    .csr_o  (status_o)
  );

  assign result_o = result_q;
  assign valid_o  = valid_q;

  AST_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[RES_W-1:WORD_W] == {WORD_W{result_o[WORD_W-1]}}); // R3
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R9
  AST_OTHER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) <= 1 && (status_o[FLAG_POS-1:0] == '0)); // R8
endmodule

// File: tb/qb_shl_top_tb.sv
module qb_shl_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [2:0]  shamt_i = '0;
  logic        flag_clr_i = 1'b0;
  logic [63:0] result_o;
  logic        valid_o;
  logic [31:0] status_o;

  int checks = 0;
  int errors = 0;
  logic exp_flag = 1'b0;
  logic [63:0] exp_res = '0;

  always #10 clk_i = ~clk_i;

  qb_shl_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opnd_i(opnd_i),
    .shamt_i(shamt_i), .flag_clr_i(flag_clr_i), .result_o(result_o),
    .valid_o(valid_o), .status_o(status_o)
  );

  function automatic logic [63:0] ref_res(input logic [31:0] a, input logic [2:0] s);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] b;
      b = a[l*8 +: 8];
      for (int k = 0; k < 8; k++) w[l*8+k] = (k >= s) ? b[k-s] : 1'b0;
    end
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic ref_ovf(input logic [31:0] a, input logic [2:0] s);
    logic o = 1'b0;
    if (s == 0) return 1'b0;
    for (int l = 0; l < 4; l++)
      for (int k = 0; k <= s; k++)
        if (a[l*8 + 7 - k]) o = 1'b1;
    return o;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge (one edge later)
  task automatic op(input logic v, input logic [31:0] a, input logic [2:0] s, input logic clr);
    valid_i = v; opnd_i = a; shamt_i = s; flag_clr_i = clr;
    if (v) exp_res = ref_res(a, s);
    if (v && ref_ovf(a, s)) exp_flag = 1'b1;
    else if (clr) exp_flag = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0; flag_clr_i = 1'b0;
    chk("R9 valid", 64'(valid_o), 64'(v));
    chk("R1 R3 result", result_o, exp_res);
    chk("R6 R7 flag", 64'(status_o[22]), 64'(exp_flag));
    chk("R8 other bits", 64'(status_o & ~32'h0040_0000), 64'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #25;
    chk("R10 reset result", result_o, 64'h0);
    chk("R10 reset valid", 64'(valid_o), 64'h0);
    chk("R10 reset status", 64'(status_o), 64'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R4: shift 0 pass-through, no overflow even with negative lanes
    op(1'b1, 32'hFF80_7F01, 3'd0, 1'b0);
    chk("R4 no ovf", 64'(status_o[22]), 64'h0);
    // R2 R5: every shift amount on all-zero, all-ones and mixed lanes
    for (int s = 0; s < 8; s++) begin
      op(1'b1, 32'h0000_0000, 3'(s), 1'b1);
      op(1'b1, 32'hFFFF_FFFF, 3'(s), 1'b1);
      op(1'b1, 32'h81_7F_01_C3, 3'(s), 1'b1);
      // single positive lane at boundary: 0x01 overflows only when s==7 (R5)
      op(1'b1, 32'h0000_0001, 3'(s), 1'b1);
      chk("R5 boundary", 64'(status_o[22]), 64'(s == 7));
    end
    // R1: no carry across lanes
    op(1'b1, 32'h8080_8080, 3'd1, 1'b1);
    chk("R1 no carry", result_o, 64'h0);
    // R6 sticky: overflow then clean op
    op(1'b1, 32'h4000_0000, 3'd2, 1'b0);
    op(1'b1, 32'h0000_0001, 3'd1, 1'b0);
    chk("R6 sticky", 64'(status_o[22]), 64'h1);
    // R9 idle hold
    op(1'b0, 32'hDEAD_BEEF, 3'd3, 1'b0);
    // R7 clear+overflow same cycle: overflow wins
    op(1'b1, 32'h0000_0040, 3'd2, 1'b1);
    chk("R7 ovf wins", 64'(status_o[22]), 64'h1);
    // R7 clear alone
    op(1'b0, 32'h0, 3'd0, 1'b1);
    chk("R7 clear", 64'(status_o[22]), 64'h0);
    // random
    for (int i = 0; i < 300; i++)
      op(1'($urandom_range(0, 3) != 0), $urandom, 3'($urandom), 1'($urandom_range(0, 5) == 0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule